// File: doc/BRIEF.md
# Multichannel Result Serializer

This block sits at the readout edge of an eight-channel converter. A load strobe captures a full set of eight channel result words in one system clock cycle. The block then sends them on one serial data line. The serial line advances one bit on each falling edge of an externally supplied data clock. An active-low ready flag tells the host that a new frame can be read. The flag drops shortly after a result set is captured and rises again on the first data-clock falling edge the host produces.

A width-select input picks 20-bit or 16-bit words. In the narrow mode, the four least significant bits of every channel word are dropped, so the frame is 128 bits long instead of 160. Result words use offset binary: zero scale is 0x01000 (0x0100 when narrow), and all ones means at or above full scale. The block passes words through unchanged and does not interpret them. The data clock is asynchronous to the system clock. It is brought into the system clock domain through a synchronizer before its falling edges are used.

Top module: `chan_readout_shifter`

## Requirements
- R1: After reset, `ready_n` is 1 and `sdata` is 0.
- R2: With `wide_sel` = 1 at load, the frame is 160 bits. Channel 8 comes first (`res_bus[159:140]`), then channel 7 and so on down to channel 1 (`res_bus[19:0]`). Each word is sent MSB first. Channel k occupies `res_bus[20k-1:20k-20]`.
- R3: With `wide_sel` = 0 at load, the frame is 128 bits. It uses the same channel order and sends only bits [19:4] of each channel word, MSB first.
- R4: Once all frame bits have been shifted out, further data-clock falling edges put 0 on `sdata`.
- R5: The first frame bit (channel 8 MSB) is on `sdata` one system clock after the load strobe is sampled. `ready_n` goes low one system clock later.
- R6: `ready_n` returns to 1 on the first data-clock falling edge detected after it went low. It stays low until that edge and stays high on further edges.
- R7: Each detected data-clock falling edge advances `sdata` by exactly one bit. Rising edges of the data clock leave `sdata` unchanged.
- R8: A load strobe in the middle of a frame restarts the frame from channel 8 MSB of the new result set and drives `ready_n` low again.
- R9: `wide_sel` is sampled only at load. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk | input | 1 | External data clock, asynchronous to clk |
| load | input | 1 | One-cycle strobe: capture a new result set |
| res_bus | input | 160 | Eight 20-bit channel results, channel 8 in the top bits |
| wide_sel | input | 1 | 1 = 20-bit words, 0 = 16-bit words |
| ready_n | output | 1 | Active-low ready flag for a new frame |
| sdata | output | 1 | Serial data out |

## Verification
The in-RTL assertions check the following on every cycle:
- the channel 8 MSB appears right after a load, and the ready flag falls two cycles after the load;
- every detected data-clock fall moves the line by exactly one bit and raises a low flag;
- the flag never rises without such a fall;
- the line holds still when there is neither a fall nor a load.

The complete bit order across both word widths, the zero fill after a frame, restart on a mid-frame reload, and immunity to a width change after the load can only be shown by the bench's scenarios. Each scenario compares every serial bit against a frame model built from the stated word layout.

// File: rtl/readout_pkg.sv
package readout_pkg;
   localparam int unsigned RO_NUM_CH  = 8;
   localparam int unsigned RO_WORD_W  = 20;
   localparam int unsigned RO_TRUNC_W = 4;
   localparam int unsigned RO_SYNC_N  = 2;

   // number of bits in a frame for a given word width selection
   function automatic int unsigned frame_bits(input int unsigned nch,
                                              input int unsigned word_w,
                                              input int unsigned trunc_w,
                                              input logic        wide);
      return wide ? nch * word_w : nch * (word_w - trunc_w);
   endfunction
endpackage

// File: rtl/ro_fall_detect.sv
module ro_fall_detect #(
   parameter int unsigned SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_evt
);
   logic [SYNC_N-1:0] sync_q;
   logic              last_q;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("ro_fall_detect: SYNC_N must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], async_in};
         last_q <= sync_q[SYNC_N-1];
      end
   end

   assign fall_evt = last_q & ~sync_q[SYNC_N-1];
endmodule

// File: rtl/ro_frame_pack.sv
module ro_frame_pack #(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned WORD_W    = 20,
   parameter int unsigned TRUNC_W   = 4,
   parameter bit          NARROW_EN = 1'b1,
   localparam int unsigned FRAME_W  = NUM_CH * WORD_W,
   localparam int unsigned SHORT_W  = WORD_W - TRUNC_W,
   localparam int unsigned PAD_W    = NUM_CH * TRUNC_W
) (
   input  logic [FRAME_W-1:0] words,
   input  logic               wide,
   output logic [FRAME_W-1:0] frame
);
   if (TRUNC_W >= WORD_W) begin : g_bad_trunc
      $error("ro_frame_pack: TRUNC_W must be below WORD_W");
   end

   if (NARROW_EN) begin : g_narrow
      logic [NUM_CH*SHORT_W-1:0] short_words;
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign short_words[c*SHORT_W +: SHORT_W] = words[c*WORD_W + TRUNC_W +: SHORT_W];
      end
      assign frame = wide ? words : {short_words, {PAD_W{1'b0}}};
   end else begin : g_wide_only
      logic unused_wide;
      assign unused_wide = wide;
      assign frame       = words;
   end
endmodule

// File: rtl/chan_readout_shifter.sv
module chan_readout_shifter
   import readout_pkg::*;
#(
   parameter int unsigned NUM_CH    = RO_NUM_CH,
   parameter int unsigned WORD_W    = RO_WORD_W,
   parameter int unsigned TRUNC_W   = RO_TRUNC_W,
   parameter int unsigned SYNC_N    = RO_SYNC_N,
   parameter bit          NARROW_EN = 1'b1,
   localparam int unsigned FRAME_W  = NUM_CH * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dclk,
   input  logic               load,
   input  logic [FRAME_W-1:0] res_bus,
   input  logic               wide_sel,
   output logic               ready_n,
   output logic               sdata
);
   if (NUM_CH < 1 || WORD_W < 2) begin : g_bad_geom
      $error("chan_readout_shifter: NUM_CH and WORD_W out of range");
   end

   logic               fall_evt;
   logic [FRAME_W-1:0] packed_frame;
   logic [FRAME_W-1:0] shreg;
   logic               pend_q;
   logic               rdy_n_q;

   ro_fall_detect #(.SYNC_N(SYNC_N)) u_fall (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (dclk),
      .fall_evt (fall_evt)
   );

   ro_frame_pack #(
      .NUM_CH   (NUM_CH),
      .WORD_W   (WORD_W),
      .TRUNC_W  (TRUNC_W),
      .NARROW_EN(NARROW_EN)
   ) u_pack (
      .words (res_bus),
      .wide  (wide_sel),
      .frame (packed_frame)
   );

   // shift register: load has priority; falls are held off during the pending cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (load) begin
         shreg <= packed_frame;
      end else if (fall_evt && !pend_q) begin
         shreg <= {shreg[FRAME_W-2:0], 1'b0};
      end
   end

   // ready flag: falls one cycle after the first bit is placed, rises on a fall
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         rdy_n_q <= 1'b1;
      end else begin
         pend_q <= load;
         if (pend_q && !load) begin
            rdy_n_q <= 1'b0;
         end else if (fall_evt && !pend_q && !load) begin
            rdy_n_q <= 1'b1;
         end
      end
   end

   assign sdata   = shreg[FRAME_W-1];
   assign ready_n = rdy_n_q;

   assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sdata == $past(res_bus[FRAME_W-1])));

   assert_flag_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load ##1 !load) |=> !ready_n);

   assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && !pend_q && !load) |=> ready_n);

   assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_n) |-> $past(fall_evt));

   assert_shift_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && !pend_q && !load) |=> (sdata == $past(shreg[FRAME_W-2])));

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_evt && !load) |=> $stable(sdata));
endmodule

// File: tb/tb_chan_readout_shifter.sv
module tb_chan_readout_shifter;
   localparam int unsigned FW = 160;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dclk = 1'b1;
   logic          load = 1'b0;
   logic [FW-1:0] res_bus = '0;
   logic          wide_sel = 1'b1;
   logic          ready_n;
   logic          sdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   chan_readout_shifter dut (
      .clk(clk), .rst_n(rst_n), .dclk(dclk), .load(load),
      .res_bus(res_bus), .wide_sel(wide_sel), .ready_n(ready_n), .sdata(sdata)
   );

   // {wide, data}; channel 8 in the top 20 bits
   localparam logic [FW:0] VECS [3] = '{
      {1'b1, 160'hFFFFF010001234_5ABCDE0000001001_5A5A5C3C3C},
      {1'b0, 160'hFFFFF010001234_5ABCDE0000001001_5A5A5C3C3C},
      {1'b1, 160'h9876543210FEDCBA0123456789ABCDEF00FF11EE}
   };

   function automatic logic exp_bit(input logic [FW-1:0] d, input logic wide, input int idx);
      int nb = wide ? 20 : 16;
      if (idx >= 8 * nb) return 1'b0;
      return d[(7 - idx / nb) * 20 + (19 - idx % nb)];
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [FW-1:0] d, input logic wide);
      @(negedge clk);
      res_bus = d; wide_sel = wide; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   // drive one data-clock falling edge, sample after sync latency, then raise it
   task automatic dfall(output logic b);
      dclk = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      b = sdata;
      dclk = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   // reads bits start..n-1 (bit "start" is already on the line)
   task automatic read_bits(input string req, input logic [FW-1:0] d, input logic wide,
                            input int start, input int n, output int errs);
      logic b;
      errs = 0;
      if (sdata !== exp_bit(d, wide, start)) errs++;
      for (int i = start + 1; i < n; i++) begin
         dfall(b);
         if (b !== exp_bit(d, wide, i)) begin
            errs++;
            if (errs == 1)
               $display("FAIL %s bit %0d actual=%0b expected=%0b", req, i, b, exp_bit(d, wide, i));
         end
      end
   endtask

   initial begin
      int errs;
      logic b;
      logic [FW-1:0] d;
      logic w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 ready_n reset", ready_n, 1'b1);
      check("R1 sdata reset", sdata, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: full frames plus trailing zeros
      for (int v = 0; v < 3; v++) begin
         w = VECS[v][FW];
         d = VECS[v][FW-1:0];
         do_load(d, w);
         check("R5 msb before flag", sdata, exp_bit(d, w, 0));
         check("R5 flag still high", ready_n, 1'b1);
         @(negedge clk);
         check("R5 flag low", ready_n, 1'b0);
         repeat (10) @(negedge clk);
         check("R6 flag held low", ready_n, 1'b0);
         dfall(b);
         check("R6 flag high after first fall", ready_n, 1'b1);
         check("R7 second bit", b, exp_bit(d, w, 1));
         read_bits(w ? "R2 wide frame" : "R3 narrow frame", d, w, 1, (w ? 160 : 128) + 6, errs);
         checks++;
         if (errs != 0) begin
            fails++;
            $display("FAIL %s errors actual=%0d expected=0", w ? "R2" : "R3", errs);
         end
         check("R4 zero fill", sdata, 1'b0);
         check("R6 flag stays high", ready_n, 1'b1);
      end

      // R7: a rising edge alone does not move the line
      d = VECS[2][FW-1:0];
      do_load(d, 1'b1);
      repeat (4) @(negedge clk);
      dfall(b);
      dclk = 1'b0;
      repeat (5) @(negedge clk);
      b = sdata;
      dclk = 1'b1;
      repeat (6) @(negedge clk);
      check("R7 rising edge no shift", sdata, b);

      // R8: reload in the middle of a frame
      d = VECS[0][FW-1:0];
      do_load(d, 1'b1);
      for (int i = 0; i < 30; i++) dfall(b);
      d = VECS[2][FW-1:0];
      do_load(d, 1'b1);
      check("R8 restart msb", sdata, exp_bit(d, 1'b1, 0));
      @(negedge clk);
      check("R8 flag low again", ready_n, 1'b0);
      read_bits("R8 reloaded frame", d, 1'b1, 0, 160, errs);
      check("R8 reloaded frame intact", errs == 0, 1'b1);

      // R9: width change after load is ignored
      d = VECS[0][FW-1:0];
      do_load(d, 1'b1);
      repeat (2) @(negedge clk);
      read_bits("R9 pre-change", d, 1'b1, 0, 10, errs);
      wide_sel = 1'b0;
      read_bits("R9 post-change", d, 1'b1, 9, 162, errs);
      check("R9 width sampled at load", errs == 0, 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule